// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block turns a table of memory region descriptors into a stream of burst requests for a disk-side byte transfer. A transfer begins with a start pulse. The pulse carries three values: the table base pointer, the number of bytes the device side will move, and a direction bit. The walker fetches one 8-byte descriptor at a time over a request/response read port. Each descriptor holds a buffer address word and then a size/flags word. The walker then issues chunk requests, each an address and a length, to a memory master port that uses a valid/ready handshake.

A transfer ends in one of two ways. When every device byte has been placed, the walker pulses its completion output. When the table runs out while device bytes are still pending, it pulses its short-table output instead. The table runs out when the region flagged as last is used up, or when the table pointer has moved one 4 KiB page past the base. Chunk sizes follow the smaller of the device bytes still pending and the bytes left in the current region. A region can therefore be split across chunks, and a chunk never crosses into the next region.

Top module: `sg_table_walker`

## Requirements
- R1: A start pulse in idle loads the table pointer from `tableBase`. Each fetch requests the word address equal to the current pointer, and the pointer then advances by 8. The first response beat is the region address and the second is the size/flags word.
- R2: The region length is the size word ANDed with 0xFFFE, so bit 0 of the size word never affects any chunk length.
- R3: A masked length of zero gives a region of 65536 bytes.
- R4: Bit 31 of the size word marks the last region. Once that region is used up, no further fetch is made. If device bytes remain, `tableShort` pulses for one cycle.
- R5: No fetch is issued once the pointer has advanced 4096 or more bytes past the base, even if no last flag was seen. In that case `tableShort` pulses if device bytes remain.
- R6: Each chunk length is min(device bytes pending, region bytes left). The next chunk from the same region starts at the previous chunk's address plus its length, with no new fetch. A new descriptor is fetched only when the region is empty.
- R7: When the pending device byte count reaches zero, `xferDone` pulses for one cycle. A start with a byte count of zero gives `xferDone` with no fetch and no chunk.
- R8: `chunkWrite` is 1 for every chunk when `toMemory` was 1 at the start pulse, and 0 when it was 0.
- R9: While `descReqValid` or `chunkValid` is high and the matching ready input is low, the valid stays high and its address and length stay unchanged.
- R10: Every start reloads the pointer from the base, so a second transfer fetches its first descriptor at its own base.
- R11: After synchronous reset, no request is valid and neither end pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tableBase | input | ADDR_W | Descriptor table base, sampled at start |
| xferStart | input | 1 | Start pulse, used only while idle |
| toMemory | input | 1 | 1: device to memory (chunks are writes) |
| xferBytes | input | CNT_W | Device byte count, sampled at start |
| descReqValid | output | 1 | Descriptor fetch request valid |
| descReqReady | input | 1 | Descriptor fetch request accepted |
| descReqAddr | output | ADDR_W | Address of the descriptor to fetch |
| descRspValid | input | 1 | Descriptor response beat valid |
| descRspData | input | 32 | Response word: address beat, then size/flags beat |
| chunkValid | output | 1 | Chunk request valid |
| chunkReady | input | 1 | Chunk request accepted |
| chunkAddr | output | ADDR_W | Chunk start address |
| chunkLen | output | LEN_W | Chunk length in bytes (1..65536) |
| chunkWrite | output | 1 | 1: memory write, 0: memory read |
| xferDone | output | 1 | One-cycle pulse: all device bytes placed |
| tableShort | output | 1 | One-cycle pulse: table ended with bytes pending |

## Verification
Several properties are checked on every cycle. Both handshakes must hold valid, address and length while stalled. A fetch may never issue from beyond the one-page window. A chunk length must lie between 1 and 65536, and an odd length may appear only as the final chunk that drains the pending count. The two end pulses must agree with the pending count. The order and values of fetches and chunks can only be shown by the bench's scenarios: the 64 KiB zero-length decode, the ignored bit 0, the split of a region across chunks, the direction bit, the reload of the pointer on restart, and which end pulse closes each transfer.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_REQ,
    ST_WORD0,
    ST_WORD1,
    ST_ISSUE
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic takeFetch;
    logic loadAddr;
    logic loadSize;
    logic takeChunk;
    logic flagDone;
    logic flagShort;
  } walkStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic pendingZero;
    logic regionZero;
    logic tableEnd;
  } walkStatus_t;

endpackage

// File: rtl/sgw_ctrl.sv
module sgw_ctrl
  import sgw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        xferStart,
  input  logic        descReqReady,
  input  logic        descRspValid,
  input  logic        chunkReady,
  input  walkStatus_t status,
  output walkStrobe_t strobe,
  output logic        descReqValid,
  output logic        chunkValid
);

  walkState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState    = state;
    strobe       = '0;
    descReqValid = 1'b0;
    chunkValid   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (xferStart) begin
          strobe.loadStart = 1'b1;
          nextState        = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (status.pendingZero) begin
          strobe.flagDone = 1'b1;
          nextState       = ST_IDLE;
        end else if (status.regionZero) begin
          if (status.tableEnd) begin
            strobe.flagShort = 1'b1;
            nextState        = ST_IDLE;
          end else begin
            nextState = ST_REQ;
          end
        end else begin
          nextState = ST_ISSUE;
        end
      end
      ST_REQ: begin
        descReqValid = 1'b1;
        if (descReqReady) begin
          strobe.takeFetch = 1'b1;
          nextState        = ST_WORD0;
        end
      end
      ST_WORD0: begin
        if (descRspValid) begin
          strobe.loadAddr = 1'b1;
          nextState       = ST_WORD1;
        end
      end
      ST_WORD1: begin
        if (descRspValid) begin
          strobe.loadSize = 1'b1;
          nextState       = ST_CHECK;
        end
      end
      ST_ISSUE: begin
        chunkValid = 1'b1;
        if (chunkReady) begin
          strobe.takeChunk = 1'b1;
          nextState        = ST_CHECK;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R9: a stalled fetch request is not withdrawn
  a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
    descReqValid && !descReqReady |=> descReqValid);

  // R9: a stalled chunk request is not withdrawn
  a_r9_chunk_hold: assert property (@(posedge clk) disable iff (rst)
    chunkValid && !chunkReady |=> chunkValid);

endmodule

// File: rtl/sgw_datapath.sv
module sgw_datapath
  import sgw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 24,
  parameter int REGION_BITS = 16,
  parameter int PAGE_BYTES  = 4096,
  parameter int DESC_BYTES  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  walkStrobe_t              strobe,
  input  logic                     issuing,
  input  logic [ADDR_W-1:0]        tableBase,
  input  logic                     toMemory,
  input  logic [CNT_W-1:0]         xferBytes,
  input  logic [ADDR_W-1:0]        rspAddrWord,
  input  logic                     rspLastBit,
  input  logic [REGION_BITS-1:0]   rspLenBits,
  output walkStatus_t              status,
  output logic [ADDR_W-1:0]        fetchAddr,
  output logic [ADDR_W-1:0]        chunkAddr,
  output logic [REGION_BITS:0]     chunkLen,
  output logic                     chunkWrite,
  output logic                     doneQ,
  output logic                     shortQ
);

  localparam int LEN_W = REGION_BITS + 1;
  localparam int CMP_W = (CNT_W > LEN_W) ? CNT_W : LEN_W;
  localparam logic [LEN_W-1:0]  FULL_REGION = LEN_W'(1) << REGION_BITS;
  localparam logic [ADDR_W-1:0] PAGE_LIMIT  = ADDR_W'(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] DESC_STEP   = ADDR_W'(DESC_BYTES);

  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] curPtr;
  logic [ADDR_W-1:0] regionAddr;
  logic [LEN_W-1:0]  regionLen;
  logic              lastFlag;
  logic [CNT_W-1:0]  pending;
  logic              dirQ;

  logic [ADDR_W-1:0] tableOffset;
  logic [LEN_W-1:0]  maskedLen;
  logic [LEN_W-1:0]  decodedLen;
  logic [CMP_W-1:0]  pendWide;
  logic [CMP_W-1:0]  regionWide;
  logic [CMP_W-1:0]  chunkWide;

  // descriptor size decode: bit 0 dropped, zero means a full region
  always_comb begin
    maskedLen  = LEN_W'({rspLenBits[REGION_BITS-1:1], 1'b0});
    decodedLen = (maskedLen == '0) ? FULL_REGION : maskedLen;
  end

  // chunk sizing: smaller of pending device bytes and region remainder
  always_comb begin
    pendWide   = CMP_W'(pending);
    regionWide = CMP_W'(regionLen);
    chunkWide  = (pendWide < regionWide) ? pendWide : regionWide;
    chunkLen   = LEN_W'(chunkWide);
  end

  always_comb begin
    tableOffset        = curPtr - baseQ;
    status.pendingZero = (pending == '0);
    status.regionZero  = (regionLen == '0);
    status.tableEnd    = lastFlag || (tableOffset >= PAGE_LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      baseQ      <= '0;
      curPtr     <= '0;
      regionAddr <= '0;
      regionLen  <= '0;
      lastFlag   <= 1'b0;
      pending    <= '0;
      dirQ       <= 1'b0;
      doneQ      <= 1'b0;
      shortQ     <= 1'b0;
    end else begin
      doneQ  <= strobe.flagDone;
      shortQ <= strobe.flagShort;
      if (strobe.loadStart) begin
        baseQ     <= tableBase;
        curPtr    <= tableBase;
        regionLen <= '0;
        lastFlag  <= 1'b0;
        pending   <= xferBytes;
        dirQ      <= toMemory;
      end
      if (strobe.takeFetch) curPtr <= curPtr + DESC_STEP;
      if (strobe.loadAddr)  regionAddr <= rspAddrWord;
      if (strobe.loadSize) begin
        regionLen <= decodedLen;
        lastFlag  <= rspLastBit;
      end
      if (strobe.takeChunk) begin
        regionAddr <= regionAddr + ADDR_W'(chunkLen);
        regionLen  <= regionLen - chunkLen;
        pending    <= pending - CNT_W'(chunkLen);
      end
    end
  end

  assign fetchAddr  = curPtr;
  assign chunkAddr  = regionAddr;
  assign chunkWrite = dirQ;

  // R5: a fetch is never taken from outside the one-page window
  a_r5_fetch_in_page: assert property (@(posedge clk) disable iff (rst)
    strobe.takeFetch |-> (curPtr - baseQ) < PAGE_LIMIT);

  // R2: regions are even, so an odd chunk must drain the pending count
  a_r2_odd_only_final: assert property (@(posedge clk) disable iff (rst)
    issuing && chunkLen[0] |-> CNT_W'(chunkLen) == pending);

  // R4: a short-table pulse only while device bytes remain
  a_r4_short_has_data: assert property (@(posedge clk) disable iff (rst)
    shortQ |-> pending != '0);

  // R7: completion only with nothing pending
  a_r7_done_empty: assert property (@(posedge clk) disable iff (rst)
    doneQ |-> pending == '0);

endmodule

// File: rtl/sg_table_walker.sv
module sg_table_walker
  import sgw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 24,
  parameter int REGION_BITS = 16,
  parameter int PAGE_BYTES  = 4096,
  parameter int DESC_BYTES  = 8,
  localparam int LEN_W      = REGION_BITS + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic              xferStart,
  input  logic              toMemory,
  input  logic [CNT_W-1:0]  xferBytes,
  output logic              descReqValid,
  input  logic              descReqReady,
  output logic [ADDR_W-1:0] descReqAddr,
  input  logic              descRspValid,
  input  logic [31:0]       descRspData,
  output logic              chunkValid,
  input  logic              chunkReady,
  output logic [ADDR_W-1:0] chunkAddr,
  output logic [LEN_W-1:0]  chunkLen,
  output logic              chunkWrite,
  output logic              xferDone,
  output logic              tableShort
);

  walkStrobe_t strobe;
  walkStatus_t status;

  sgw_ctrl ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .xferStart    (xferStart),
    .descReqReady (descReqReady),
    .descRspValid (descRspValid),
    .chunkReady   (chunkReady),
    .status       (status),
    .strobe       (strobe),
    .descReqValid (descReqValid),
    .chunkValid   (chunkValid)
  );

  sgw_datapath #(
    .ADDR_W      (ADDR_W),
    .CNT_W       (CNT_W),
    .REGION_BITS (REGION_BITS),
    .PAGE_BYTES  (PAGE_BYTES),
    .DESC_BYTES  (DESC_BYTES)
  ) dp_i (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .issuing     (chunkValid),
    .tableBase   (tableBase),
    .toMemory    (toMemory),
    .xferBytes   (xferBytes),
    .rspAddrWord (ADDR_W'(descRspData)),
    .rspLastBit  (descRspData[31]),
    .rspLenBits  (descRspData[REGION_BITS-1:0]),
    .status      (status),
    .fetchAddr   (descReqAddr),
    .chunkAddr   (chunkAddr),
    .chunkLen    (chunkLen),
    .chunkWrite  (chunkWrite),
    .doneQ       (xferDone),
    .shortQ      (tableShort)
  );

  // R9: chunk payload frozen while stalled
  a_r9_chunk_stable: assert property (@(posedge clk) disable iff (rst)
    chunkValid && !chunkReady |=> $stable(chunkAddr) && $stable(chunkLen) && $stable(chunkWrite));

  // R9: fetch address frozen while stalled
  a_r9_req_stable: assert property (@(posedge clk) disable iff (rst)
    descReqValid && !descReqReady |=> $stable(descReqAddr));

  // R3: every chunk is between one byte and a full region
  a_r3_len_range: assert property (@(posedge clk) disable iff (rst)
    chunkValid |-> (chunkLen != '0) && (chunkLen <= (LEN_W'(1) << REGION_BITS)));

endmodule

// File: tb/sg_table_walker_tb_top.sv
module sg_table_walker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 24;
  localparam int LEN_W  = 17;
  localparam int WATCHDOG_CYCLES = 150000;

  typedef struct {
    int          kind;   // 0 fetch, 1 chunk, 2 done, 3 short
    logic [31:0] addr;
    logic [31:0] len;
    logic        wr;
    string       tag;
  } item_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] tableBase = '0;
  logic              xferStart = 1'b0;
  logic              toMemory = 1'b0;
  logic [CNT_W-1:0]  xferBytes = '0;
  logic              descReqValid;
  logic              descReqReady = 1'b1;
  logic [ADDR_W-1:0] descReqAddr;
  logic              descRspValid = 1'b0;
  logic [31:0]       descRspData = '0;
  logic              chunkValid;
  logic              chunkReady = 1'b1;
  logic [ADDR_W-1:0] chunkAddr;
  logic [LEN_W-1:0]  chunkLen;
  logic              chunkWrite;
  logic              xferDone;
  logic              tableShort;

  int checks = 0;
  int errors = 0;
  int cycle = 0;
  bit stallMode = 1'b0;
  bit endSeen = 1'b0;
  bit reqFire = 1'b0;
  bit finished = 1'b0;
  logic [31:0] reqAddr = '0;
  int rspStage = 0;
  item_t expQ[$];
  logic [31:0] mem[logic [31:0]];

  sg_table_walker dut_i (
    .clk(clk), .rst(rst), .tableBase(tableBase), .xferStart(xferStart),
    .toMemory(toMemory), .xferBytes(xferBytes),
    .descReqValid(descReqValid), .descReqReady(descReqReady), .descReqAddr(descReqAddr),
    .descRspValid(descRspValid), .descRspData(descRspData),
    .chunkValid(chunkValid), .chunkReady(chunkReady), .chunkAddr(chunkAddr),
    .chunkLen(chunkLen), .chunkWrite(chunkWrite),
    .xferDone(xferDone), .tableShort(tableShort)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rdWord(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic putDesc(logic [31:0] a, logic [31:0] buf_addr, logic [31:0] sz);
    mem[a]     = buf_addr;
    mem[a + 4] = sz;
  endtask

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic pushItem(int kind, logic [31:0] a, logic [31:0] l, logic w, string tag);
    item_t it;
    it.kind = kind; it.addr = a; it.len = l; it.wr = w; it.tag = tag;
    expQ.push_back(it);
  endtask

  // independent model of the walk, producing the expected event order
  task automatic modelWalk(logic [31:0] base, int count, logic dir, string chunkTag, string shortTag);
    logic [31:0] ptr = base;
    logic [31:0] raddr = 0;
    int rlen = 0;
    bit last = 0;
    int pend = count;
    for (int guard = 0; guard < 5000; guard++) begin
      if (pend == 0) begin
        pushItem(2, 0, 0, 0, "R7");
        return;
      end
      if (rlen == 0) begin
        if (last || (ptr - base) >= 4096) begin
          pushItem(3, 0, 0, 0, shortTag);
          return;
        end
        pushItem(0, ptr, 0, 0, "R1");
        raddr = rdWord(ptr);
        rlen  = int'(rdWord(ptr + 4) & 32'hFFFE);
        if (rlen == 0) rlen = 65536;
        last  = rdWord(ptr + 4)[31];
        ptr   = ptr + 8;
      end else begin
        int l = (pend < rlen) ? pend : rlen;
        pushItem(1, raddr, l, dir, chunkTag);
        raddr = raddr + l;
        rlen  = rlen - l;
        pend  = pend - l;
      end
    end
  endtask

  task automatic runXfer(logic [31:0] base, int count, logic dir, string chunkTag, string shortTag);
    modelWalk(base, count, dir, chunkTag, shortTag);
    endSeen = 1'b0;
    @(posedge clk); #1;
    tableBase = base; xferBytes = CNT_W'(count); toMemory = dir; xferStart = 1'b1;
    @(posedge clk); #1;
    xferStart = 1'b0;
    while (!endSeen) @(posedge clk);
    repeat (3) @(posedge clk);
    chk(expQ.size() == 0, chunkTag, "events left in queue", expQ.size(), 0);
    expQ.delete();
  endtask

  // ready drivers and descriptor memory responder, all 1 time unit after the edge
  always @(posedge clk) begin
    #1;
    cycle++;
    descReqReady = stallMode ? (cycle % 2 == 0) : 1'b1;
    chunkReady   = stallMode ? (cycle % 3 == 0) : 1'b1;
    descRspValid = 1'b0;
    if (reqFire) begin
      descRspValid = 1'b1;
      descRspData  = rdWord(reqAddr);
      rspStage     = 1;
      reqFire      = 1'b0;
    end else if (rspStage == 1) begin
      descRspValid = 1'b1;
      descRspData  = rdWord(reqAddr + 4);
      rspStage     = 0;
    end
  end

  // monitor: samples between edges and compares with the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      item_t it;
      if (descReqValid && descReqReady) begin
        reqFire = 1'b1;
        reqAddr = descReqAddr;
        if (expQ.size() == 0) chk(0, "R1", "unexpected fetch", descReqAddr, 0);
        else begin
          it = expQ.pop_front();
          chk(it.kind == 0, it.tag, "event kind (fetch)", 0, it.kind);
          chk(descReqAddr == it.addr, it.tag, "fetch address", descReqAddr, it.addr);
        end
      end
      if (chunkValid && chunkReady) begin
        if (expQ.size() == 0) chk(0, "R6", "unexpected chunk", chunkAddr, 0);
        else begin
          it = expQ.pop_front();
          chk(it.kind == 1, it.tag, "event kind (chunk)", 1, it.kind);
          chk(chunkAddr == it.addr, it.tag, "chunk address", chunkAddr, it.addr);
          chk(32'(chunkLen) == it.len, it.tag, "chunk length", 32'(chunkLen), it.len);
          chk(chunkWrite == it.wr, "R8", "chunk direction", chunkWrite, it.wr);
        end
      end
      if (xferDone || tableShort) begin
        endSeen = 1'b1;
        if (expQ.size() == 0) chk(0, "R7", "unexpected end pulse", {xferDone, tableShort}, 0);
        else begin
          it = expQ.pop_front();
          chk(it.kind == (xferDone ? 2 : 3) && !(xferDone && tableShort), it.tag,
              "end pulse kind", xferDone ? 2 : 3, it.kind);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // tables
    putDesc(32'h1000, 32'h0002_0000, 32'h0000_0100);
    putDesc(32'h1008, 32'h0003_0000, 32'h8000_0200);
    putDesc(32'h2000, 32'h0004_0000, 32'h8000_0101);
    putDesc(32'h3000, 32'h0050_0000, 32'h8000_0000);
    putDesc(32'h5000, 32'h0006_0000, 32'h0000_0081);
    putDesc(32'h5008, 32'h0007_0000, 32'h0001_0040);
    putDesc(32'h5010, 32'h0008_0000, 32'h8000_1000);
    for (int i = 0; i < 520; i++)
      putDesc(32'h8000 + 32'(i) * 8, 32'h0100_0000 + 32'(i) * 32'h10, 32'h0000_0002);

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk(!descReqValid, "R11", "descReqValid in reset", descReqValid, 0);
    chk(!chunkValid,   "R11", "chunkValid in reset", chunkValid, 0);
    chk(!xferDone && !tableShort, "R11", "end pulses in reset", {xferDone, tableShort}, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk(!descReqValid && !chunkValid, "R11", "idle after reset", {descReqValid, chunkValid}, 0);

    // R6: two regions, write direction
    runXfer(32'h1000, 32'h300, 1'b1, "R6", "R4");
    // R2: bit 0 of size ignored, region 0x100
    runXfer(32'h2000, 32'h100, 1'b0, "R2", "R4");
    // R6: device shorter than region, odd final chunk
    runXfer(32'h2000, 32'h0C1, 1'b1, "R6", "R4");
    // R3 and R4: zero length is 64 KiB; table ends first
    runXfer(32'h3000, 32'h18000, 1'b1, "R3", "R4");
    // R7: zero byte count
    runXfer(32'h1000, 0, 1'b1, "R7", "R4");
    // R9 and R8: stalled handshakes, memory-to-device, mixed sizes
    stallMode = 1'b1;
    runXfer(32'h5000, 32'h1100, 1'b0, "R9", "R4");
    runXfer(32'h1000, 32'h280, 1'b1, "R8", "R4");
    stallMode = 1'b0;
    // R5: page guard with no last flag
    runXfer(32'h8000, 32'h10000, 1'b1, "R5", "R5");
    // R10: restart reloads pointer from a new base
    runXfer(32'h1000, 32'h300, 1'b0, "R10", "R4");

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule